// File: doc/BRIEF.md
# Five-port dimension-ordered mesh router

This block is the switch at one node of a two-dimensional mesh. It has five ports: four toward the neighbours (west, east, south, north) and one toward the node's own processor. Every port has an input queue and an output. A flit that reaches the head of a queue is steered by plain arithmetic. The router takes the signed offset between the flit's destination coordinate and the node's own coordinate. It first removes the X offset and only then the Y offset. A flit already at its destination goes to the processor port.

Each output has a round-robin scheduler. The scheduler picks one of the queue heads that want that output, and a crossbar carries the chosen flit across. Packets are a single flit. The flit layout, from bit 0 upward, is: payload (PW bits), destination X (XW bits), destination Y (YW bits), hop count (HW bits). Neighbours decode the same layout. Each hop between routers adds one to the hop count, so a flit delivered anywhere in the mesh has a hop count equal to |Dx| + |Dy|.

Routers are tiled by joining each output to the opposite input of the neighbour. Valid flows with the data and ready flows back. Ports at the mesh boundary are tied off.

Top module: `mesh_router`

## Requirements
- R1: Port indices are west=0, east=1, south=2, north=3, local=4. A head flit whose destination X is below the local X leaves on west (0). A head flit whose destination X is above the local X leaves on east (1).
- R2: A head flit whose destination X equals the local X leaves on south (2) when its destination Y is below the local Y, and on north (3) when its destination Y is above the local Y.
- R3: A head flit whose destination X and Y both equal the local coordinate leaves on the local port (4).
- R4: Each output grants one requesting queue head per cycle, in round-robin order. The search starts at input 0 after reset, and after each completed transfer it starts at the input after the winner. While an output is stalled, its current grant is held.
- R5: An input takes a flit only while its queue holds fewer than DEPTH flits, and inReady is low while the queue is full. A flit offered while inReady is low is discarded. Flits leave one input in arrival order.
- R6: While outValid is high and outReady is low, outValid stays high and outFlit stays unchanged in the next cycle.
- R7: Only a queue head may request. A head that is blocked stalls every flit behind it, even flits that want an output that is idle.
- R8: The flit layout, from bit 0, is payload[PW], destX[XW], destY[YW], hop[HW]. Leaving on ports 0 to 3 adds one to hop. Leaving on port 4 keeps hop unchanged. All other fields are carried through unchanged.
- R9: A flit accepted at a clock edge into an empty queue is presented on its output right after that edge, provided no other head wins that output.
- R10: During reset and right after it, every outValid is low and every inReady is high.
- R11: In a mesh of these routers, every packet arrives once at the local port of its destination node with hop equal to |Dx| + |Dy|, and no packet is driven onto a boundary port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| locX | input | XW | X coordinate of this node |
| locY | input | YW | Y coordinate of this node |
| inValid | input | 5 | Per input port: flit offered |
| inFlit | input | 5 x FW | Per input port: offered flit |
| inReady | output | 5 | Per input port: queue has room |
| outValid | output | 5 | Per output port: flit presented |
| outFlit | output | 5 x FW | Per output port: presented flit |
| outReady | input | 5 | Per output port: downstream takes the flit |

## Verification
The routing checks compare each presented flit against locX and locY as they are now. They therefore assume the node coordinate stays constant after reset. The bench ties the coordinates to constants for every router.

The hop checks assume the hop field never wraps. The bench keeps every hop count far below its limit. The mesh traffic also assumes that every destination lies inside the mesh. Because of this, a boundary port is never requested, and the bench flags any flit that appears on one.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NP = 5;
  localparam int PIW = 3;
  localparam int PORT_W = 0;
  localparam int PORT_E = 1;
  localparam int PORT_S = 2;
  localparam int PORT_N = 3;
  localparam int PORT_L = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic [NP-1:0]         pop;   // dequeue head of input i
    logic [NP-1:0][NP-1:0] sel;   // sel[o][i]: output o takes input i
    logic [NP-1:0]         send;  // output o presents a flit
  } xbar_ctrl_t;
endpackage

// File: rtl/mr_datapath.sv
module mr_datapath
  import mesh_router_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2,
  parameter int PW = 8,
  parameter int HW = 4,
  parameter int DEPTH = 4,
  localparam int FW = PW + XW + YW + HW
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NP-1:0]          inValid,
  input  logic [NP-1:0][FW-1:0]  inFlit,
  output logic [NP-1:0]          inReady,
  output logic [NP-1:0]          headValid,
  output logic [NP-1:0][XW-1:0]  headDestX,
  output logic [NP-1:0][YW-1:0]  headDestY,
  input  xbar_ctrl_t             ctl,
  output logic [NP-1:0]          outValid,
  output logic [NP-1:0][FW-1:0]  outFlit
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic [NP-1:0][FW-1:0] headFlit;

  for (genvar i = 0; i < NP; i++) begin : g_fifo
    logic [FW-1:0] mem [DEPTH];
    logic [AW-1:0] rdPtr, wrPtr;
    logic [CW-1:0] count;
    logic push;

    assign inReady[i]   = (count != CW'(DEPTH));
    assign push         = inValid[i] && inReady[i];
    assign headValid[i] = (count != '0);
    assign headFlit[i]  = mem[rdPtr];
    assign headDestX[i] = headFlit[i][PW +: XW];
    assign headDestY[i] = headFlit[i][PW + XW +: YW];

    always_ff @(posedge clk) begin
      if (push) mem[wrPtr] <= inFlit[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdPtr <= '0;
        wrPtr <= '0;
        count <= '0;
      end else begin
        if (push) wrPtr <= bump(wrPtr);
        if (ctl.pop[i]) rdPtr <= bump(rdPtr);
        count <= count + CW'(push) - CW'(ctl.pop[i]);
      end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
      count <= CW'(DEPTH));
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
      ctl.pop[i] |-> headValid[i]);
  end

  for (genvar o = 0; o < NP; o++) begin : g_xbar
    logic [FW-1:0] picked;
    always_comb begin
      picked = '0;
      for (int i = 0; i < NP; i++) begin
        if (ctl.sel[o][i]) picked = picked | headFlit[i];
      end
    end
    if (o == PORT_L) begin : g_keep
      assign outFlit[o] = picked;
    end else begin : g_inc
      assign outFlit[o] = {picked[FW-1 -: HW] + HW'(1), picked[FW-HW-1:0]};
    end
    assign outValid[o] = ctl.send[o];
  end
endmodule

// File: rtl/mr_ctrl.sv
module mr_ctrl
  import mesh_router_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [XW-1:0]         locX,
  input  logic [YW-1:0]         locY,
  input  logic [NP-1:0]         headValid,
  input  logic [NP-1:0][XW-1:0] headDestX,
  input  logic [NP-1:0][YW-1:0] headDestY,
  input  logic [NP-1:0]         outReady,
  output xbar_ctrl_t            ctl
);
  logic [NP-1:0][NP-1:0] req;   // req[o][i]
  logic [NP-1:0][NP-1:0] gnt;   // gnt[o][i]
  logic [NP-1:0]         found;
  logic [NP-1:0]         popV;

  // per-input arithmetic route, X resolved before Y
  for (genvar i = 0; i < NP; i++) begin : g_route
    logic signed [XW:0] dx;
    logic signed [YW:0] dy;
    logic [PIW-1:0] dir;
    assign dx = $signed({1'b0, headDestX[i]}) - $signed({1'b0, locX});
    assign dy = $signed({1'b0, headDestY[i]}) - $signed({1'b0, locY});
    always_comb begin
      if (dx < 0)      dir = PIW'(PORT_W);
      else if (dx > 0) dir = PIW'(PORT_E);
      else if (dy < 0) dir = PIW'(PORT_S);
      else if (dy > 0) dir = PIW'(PORT_N);
      else             dir = PIW'(PORT_L);
    end
    for (genvar o = 0; o < NP; o++) begin : g_req
      assign req[o][i] = headValid[i] && (dir == PIW'(o));
    end
  end

  // per-output round-robin scheduler
  for (genvar o = 0; o < NP; o++) begin : g_arb
    logic [PIW-1:0] ptr;
    logic [NP-1:0]  grant;
    logic           any;
    int             winIdx;
    int             idx;

    always_comb begin
      grant  = '0;
      any    = 1'b0;
      winIdx = 0;
      idx    = 0;
      for (int k = 0; k < NP; k++) begin
        idx = int'(ptr) + k;
        if (idx >= NP) idx = idx - NP;
        if (!any && req[o][idx]) begin
          grant[idx] = 1'b1;
          any        = 1'b1;
          winIdx     = idx;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptr <= '0;
      else if (any) begin
        if (!outReady[o])          ptr <= PIW'(winIdx);
        else if (winIdx == NP - 1) ptr <= '0;
        else                       ptr <= PIW'(winIdx + 1);
      end
    end

    assign gnt[o]   = grant;
    assign found[o] = any;

    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(gnt[o]));
    p_grant_held_r4: assert property (@(posedge clk) disable iff (!rstN)
      found[o] && !outReady[o] |=> gnt[o] == $past(gnt[o]));
  end

  always_comb begin
    popV = '0;
    for (int i = 0; i < NP; i++) begin
      for (int o = 0; o < NP; o++) begin
        if (gnt[o][i] && outReady[o]) popV[i] = 1'b1;
      end
    end
  end

  always_comb begin
    ctl.pop  = popV;
    ctl.sel  = gnt;
    ctl.send = found;
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_router_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2,
  parameter int PW = 8,
  parameter int HW = 4,
  parameter int DEPTH = 4,
  localparam int FW = PW + XW + YW + HW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [XW-1:0]         locX,
  input  logic [YW-1:0]         locY,
  input  logic [NP-1:0]         inValid,
  input  logic [NP-1:0][FW-1:0] inFlit,
  output logic [NP-1:0]         inReady,
  output logic [NP-1:0]         outValid,
  output logic [NP-1:0][FW-1:0] outFlit,
  input  logic [NP-1:0]         outReady
);
  xbar_ctrl_t            ctl;
  logic [NP-1:0]         headValid;
  logic [NP-1:0][XW-1:0] headDestX;
  logic [NP-1:0][YW-1:0] headDestY;

  mr_datapath #(.XW(XW), .YW(YW), .PW(PW), .HW(HW), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inFlit(inFlit), .inReady(inReady),
    .headValid(headValid), .headDestX(headDestX), .headDestY(headDestY),
    .ctl(ctl), .outValid(outValid), .outFlit(outFlit)
  );

  mr_ctrl #(.XW(XW), .YW(YW)) i_ctrl (
    .clk(clk), .rstN(rstN), .locX(locX), .locY(locY),
    .headValid(headValid), .headDestX(headDestX), .headDestY(headDestY),
    .outReady(outReady), .ctl(ctl)
  );

  p_route_west_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid[PORT_W] |-> outFlit[PORT_W][PW +: XW] < locX);
  p_route_east_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid[PORT_E] |-> outFlit[PORT_E][PW +: XW] > locX);
  p_route_south_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid[PORT_S] |-> outFlit[PORT_S][PW +: XW] == locX
                      && outFlit[PORT_S][PW + XW +: YW] < locY);
  p_route_north_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid[PORT_N] |-> outFlit[PORT_N][PW +: XW] == locX
                      && outFlit[PORT_N][PW + XW +: YW] > locY);
  p_route_local_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid[PORT_L] |-> outFlit[PORT_L][PW +: XW] == locX
                      && outFlit[PORT_L][PW + XW +: YW] == locY);

  for (genvar o = 0; o < NP; o++) begin : g_hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> outValid[o] && $stable(outFlit[o]));
  end
endmodule

// File: tb/test_mesh_router.sv
module test_mesh_router;
  import mesh_router_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  // single router under directed test, node (1,1)
  logic [4:0] inV, inR, outV, outR;
  logic [4:0][15:0] inF, outF;

  mesh_router i_mesh_router (
    .clk(clk), .rstN(rstN), .locX(2'd1), .locY(2'd1),
    .inValid(inV), .inFlit(inF), .inReady(inR),
    .outValid(outV), .outFlit(outF), .outReady(outR)
  );

  // 3x3 mesh, node n at x=n%3, y=n/3
  logic [4:0] mInV [9];
  logic [4:0] mInR [9];
  logic [4:0] mOutV [9];
  logic [4:0] mOutR [9];
  logic [4:0][15:0] mInF [9];
  logic [4:0][15:0] mOutF [9];
  logic [8:0] injV;
  logic [15:0] injF [9];

  for (genvar n = 0; n < 9; n++) begin : g_node
    localparam int NX = n % 3;
    localparam int NY = n / 3;
    if (NX > 0) begin : g_w
      assign mInV[n][0] = mOutV[n-1][1];
      assign mInF[n][0] = mOutF[n-1][1];
      assign mOutR[n][0] = mInR[n-1][1];
    end else begin : g_w0
      assign mInV[n][0] = 1'b0;
      assign mInF[n][0] = '0;
      assign mOutR[n][0] = 1'b1;
    end
    if (NX < 2) begin : g_e
      assign mInV[n][1] = mOutV[n+1][0];
      assign mInF[n][1] = mOutF[n+1][0];
      assign mOutR[n][1] = mInR[n+1][0];
    end else begin : g_e0
      assign mInV[n][1] = 1'b0;
      assign mInF[n][1] = '0;
      assign mOutR[n][1] = 1'b1;
    end
    if (NY > 0) begin : g_s
      assign mInV[n][2] = mOutV[n-3][3];
      assign mInF[n][2] = mOutF[n-3][3];
      assign mOutR[n][2] = mInR[n-3][3];
    end else begin : g_s0
      assign mInV[n][2] = 1'b0;
      assign mInF[n][2] = '0;
      assign mOutR[n][2] = 1'b1;
    end
    if (NY < 2) begin : g_n
      assign mInV[n][3] = mOutV[n+3][2];
      assign mInF[n][3] = mOutF[n+3][2];
      assign mOutR[n][3] = mInR[n+3][2];
    end else begin : g_n0
      assign mInV[n][3] = 1'b0;
      assign mInF[n][3] = '0;
      assign mOutR[n][3] = 1'b1;
    end
    assign mInV[n][4] = injV[n];
    assign mInF[n][4] = injF[n];
    assign mOutR[n][4] = 1'b1;

    mesh_router i_node (
      .clk(clk), .rstN(rstN), .locX(2'(NX)), .locY(2'(NY)),
      .inValid(mInV[n]), .inFlit(mInF[n]), .inReady(mInR[n]),
      .outValid(mOutV[n]), .outFlit(mOutF[n]), .outReady(mOutR[n])
    );
  end

  function automatic logic [15:0] mkFlit(int hop, int dy, int dx, int pl);
    return {4'(hop), 2'(dy), 2'(dx), 8'(pl)};
  endfunction

  task automatic chkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // vectors for node (1,1): {destX, destY, 1'b0, port}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {2'd0, 2'd1, 1'b0, 3'd0}, {2'd2, 2'd1, 1'b0, 3'd1},
    {2'd3, 2'd3, 1'b0, 3'd1}, {2'd0, 2'd0, 1'b0, 3'd0},
    {2'd1, 2'd0, 1'b0, 3'd2}, {2'd1, 2'd3, 1'b0, 3'd3},
    {2'd1, 2'd2, 1'b0, 3'd3}, {2'd1, 2'd1, 1'b0, 3'd4}
  };

  // mesh delivery monitor (R11)
  bit [80:0] got = '0;
  int leak = 0;
  always @(negedge clk) begin
    if (rstN) begin
      for (int n = 0; n < 9; n++) begin
        int id, src, ehop, cx, cy;
        cx = n % 3;
        cy = n / 3;
        if ((cx == 0 && mOutV[n][0]) || (cx == 2 && mOutV[n][1]) ||
            (cy == 0 && mOutV[n][2]) || (cy == 2 && mOutV[n][3])) leak++;
        if (mOutV[n][4]) begin
          id = int'(mOutF[n][4][7:0]);
          src = id / 9;
          ehop = ((cx > src % 3) ? cx - src % 3 : src % 3 - cx) +
                 ((cy > src / 3) ? cy - src / 3 : src / 3 - cy);
          chkEq("R11", "mesh destination node", id % 9, n);
          chkEq("R11", "mesh hop count", int'(mOutF[n][4][15:12]), ehop);
          chkEq("R11", "mesh duplicate", int'(got[id]), 0);
          got[id] = 1'b1;
        end
      end
    end
  end

  task automatic meshRound(int d);
    logic [8:0] pend, acc;
    pend = '1;
    for (int s = 0; s < 9; s++) begin
      int dst;
      dst = (s + d) % 9;
      injF[s] = mkFlit(0, dst / 3, dst % 3, s * 9 + dst);
    end
    while (pend != 0) begin
      injV = pend;
      for (int s = 0; s < 9; s++) acc[s] = pend[s] && mInR[s][4];
      @(negedge clk);
      pend = pend & ~acc;
    end
    injV = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] f0;
    inV = '0; inF = '0; outR = '1; injV = '0;
    for (int s = 0; s < 9; s++) injF[s] = '0;
    repeat (3) @(negedge clk);
    chkEq("R10", "outValid in reset", int'(outV), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R10", "outValid after reset", int'(outV), 0);
    chkEq("R10", "inReady after reset", int'(inR), 31);

    // table walk through the local input
    for (int v = 0; v < NV; v++) begin
      int dx, dy, port, hop;
      string tag;
      dx = int'(VEC[v][7:6]);
      dy = int'(VEC[v][5:4]);
      port = int'(VEC[v][2:0]);
      hop = (port == PORT_L) ? 0 : 1;
      tag = (port < 2) ? "R1" : (port < 4) ? "R2" : "R3";
      @(negedge clk);
      inV[4] = 1'b1;
      inF[4] = mkFlit(0, dy, dx, v);
      @(negedge clk);
      inV[4] = 1'b0;
      chkEq({tag, "/R9"}, "output port one cycle later", int'(outV), 1 << port);
      chkEq({tag, "/R8"}, "flit content", int'(outF[port]), int'(mkFlit(hop, dy, dx, v)));
      @(negedge clk);
      chkEq(tag, "output idle after transfer", int'(outV), 0);
    end

    // full queue, held output, order
    outR[1] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      inV[0] = 1'b1;
      inF[0] = mkFlit(0, 1, 3, 64 + k);
    end
    @(negedge clk);
    inV[0] = 1'b0;
    chkEq("R5", "inReady with full queue", int'(inR[0]), 0);
    chkEq("R6", "stalled outValid", int'(outV[1]), 1);
    f0 = outF[1];
    inV[0] = 1'b1;
    inF[0] = mkFlit(0, 1, 3, 79);
    @(negedge clk);
    inV[0] = 1'b0;
    chkEq("R6", "stalled outValid next cycle", int'(outV[1]), 1);
    chkEq("R6", "stalled flit stable", int'(outF[1]), int'(f0));
    outR[1] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chkEq("R5", "arrival order", int'(outF[1][7:0]), 64 + k);
      @(negedge clk);
    end
    chkEq("R5", "flit offered while full discarded", int'(outV[1]), 0);

    // round-robin on north
    outR[3] = 1'b0;
    @(negedge clk);
    inV[2:0] = 3'b111;
    for (int i = 0; i < 3; i++) inF[i] = mkFlit(0, 3, 1, 16 * i);
    @(negedge clk);
    for (int i = 0; i < 3; i++) inF[i] = mkFlit(0, 3, 1, 16 * i + 1);
    @(negedge clk);
    inV[2:0] = 3'b000;
    outR[3] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      chkEq("R4", "round-robin grant order", int'(outF[3][7:0]), 16 * (k % 3) + k / 3);
      @(negedge clk);
    end

    // head-of-line blocking
    outR[1] = 1'b0;
    inV[0] = 1'b1;
    inF[0] = mkFlit(0, 1, 3, 112);
    @(negedge clk);
    inF[0] = mkFlit(0, 3, 1, 113);
    @(negedge clk);
    inV[0] = 1'b0;
    @(negedge clk);
    chkEq("R7", "flit behind blocked head held", int'(outV[3]), 0);
    chkEq("R7", "blocked head presented", int'(outV[1]), 1);
    outR[1] = 1'b1;
    chkEq("R7", "blocked head payload", int'(outF[1][7:0]), 112);
    @(negedge clk);
    chkEq("R7", "second flit after release", int'(outV[3]), 1);
    chkEq("R7", "second flit payload", int'(outF[3][7:0]), 113);
    @(negedge clk);

    // hop field, two outputs in parallel
    inV[0] = 1'b1;
    inF[0] = mkFlit(9, 0, 1, 85);
    inV[1] = 1'b1;
    inF[1] = mkFlit(3, 1, 1, 86);
    @(negedge clk);
    inV[1:0] = 2'b00;
    chkEq("R8", "hop incremented on south", int'(outF[2]), int'(mkFlit(10, 0, 1, 85)));
    chkEq("R8", "hop kept on local", int'(outF[4]), int'(mkFlit(3, 1, 1, 86)));
    @(negedge clk);

    // mesh traffic, all sources at once
    for (int d = 0; d < 9; d++) meshRound(d);
    repeat (60) @(negedge clk);
    chkEq("R11", "packets delivered", $countones(got), 81);
    chkEq("R11", "flits on boundary ports", leak, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule